// File: doc/BRIEF.md
# Remote DMA Mask-Clear Broadcast Sequencer

This block lives in a bus bridge that fronts one legacy DMA controller group whose channels are implemented out in separate peripherals rather than inside the bridge. The host may issue a single "unmask every channel" command to that group. The peripherals do not implement this command, so the bridge expands it. One host write becomes a chain of downstream writes of zero, one to the mask-all register of each remote channel that is present.

While the chain runs, the block reports busy. Any other host access that lands in the DMA controller register window gets a retry answer, so at most one request is ever outstanding. Downstream writes leave through a valid/ready issue port. `ds_valid` stays asserted, with address and data held, until the downstream side raises `ds_ready` in the same cycle. After a write is accepted, the sequencer issues nothing more until a one-cycle completion beat (`ds_resp_valid` with a code in `ds_resp`) arrives. It then moves on to the next present channel.

A completion that reports a timeout sets a sticky target-abort status bit. A completion that reports a master abort (no device select) produces a one-cycle SMI pulse, but only when the SMI enable bit in the global enable byte is set. In both cases the chain continues with the remaining channels.

Top module: `dma_mask_fanout`

## Requirements
- R1: A host write (`host_req`=1, `host_we`=1) to address `CLR_ADDR` (default 0x00DC) starts the sequence whatever the value of `host_wdata`. A read of that address starts nothing.
- R2: The command is expanded into one downstream write for each channel whose `ch_valid` bit is set when the command is accepted. Channels with a clear bit are skipped, so between zero and `NCH` writes are issued.
- R3: The downstream write for channel i targets `ch_base[i] + i + 0xF`, where `ch_base[i]` is the field `ch_base[i*DS_AW +: DS_AW]`.
- R4: Every downstream write carries data zero on `ds_data`.
- R5: Writes are issued in ascending channel order. After a write is accepted, no new `ds_valid` appears until a completion beat has been received for it.
- R6: While `ds_valid`=1 and `ds_ready`=0, `ds_valid` stays 1 and `ds_addr` holds its value in the next cycle.
- R7: `busy` rises in the cycle after the command is accepted and falls in the cycle after the completion of the last write. A command that finds no valid channel leaves `busy` low.
- R8: `host_retry` is 1 in the same cycle as a host access whose address lies in the window `DMA_LO`..`DMA_HI` (default 0x00C0..0x00DF) while `busy` is 1. It is 0 for addresses outside the window and whenever `busy` is 0.
- R9: A completion with `ds_resp`=1 (timeout) sets `sts_tabort` in the following cycle. The bit stays set and the remaining channels are still written. Codes 0 and 3 mean normal completion.
- R10: A `sts_wr` pulse with `sts_wdata` bit 11 set clears `sts_tabort` in the next cycle. Other bits have no effect. A timeout arriving in the same cycle as the clear wins, and the bit stays set.
- R11: A completion with `ds_resp`=2 (master abort) gives a `smi_pulse` of exactly one cycle, in the next cycle, only when `glbl_en` bit 4 is 1. It does not touch `sts_tabort`.
- R12: A clear-mask write made while `busy` is 1 is answered with retry and does not start another sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host access address |
| host_wdata | input | 8 | Host write data (ignored by the command) |
| host_retry | output | 1 | Retry answer for the current host access |
| ch_valid | input | NCH | Remote channel present bits |
| ch_base | input | NCH*DS_AW | Per-channel base pointers, channel i in field i |
| ds_valid | output | 1 | Downstream write request valid |
| ds_ready | input | 1 | Downstream accepts the request this cycle |
| ds_addr | output | DS_AW | Downstream write address |
| ds_data | output | DS_DW | Downstream write data (always zero) |
| ds_resp_valid | input | 1 | Completion beat for the accepted write |
| ds_resp | input | 2 | Completion code: 0 done, 1 timeout, 2 master abort, 3 done |
| glbl_en | input | 8 | Global enable byte; bit 4 enables SMI on master abort |
| sts_wr | input | 1 | Write strobe to the device status register |
| sts_wdata | input | 16 | Device status write data (write 1 to clear) |
| sts_tabort | output | 1 | Sticky target-abort status bit |
| smi_pulse | output | 1 | One-cycle SMI request |
| busy | output | 1 | Sequence in progress |

## Verification
The bench runs sparse and full channel masks and checks every downstream address. A design that ignored the present bits, or walked the channels out of order, would present a wrong address at the first mismatch. Back-pressure is held for several cycles, which exposes a design that drops or changes the request before it is taken. Host accesses made mid-sequence show whether retry is confined to the register window. They also show whether a repeated clear command starts a second chain, which would appear as an extra `ds_valid` after `busy` falls. Timeout and master-abort completions check that the sequence carries on after an error and that the SMI is gated and lasts one cycle. A timeout that coincides with a status clear must leave the bit set; a design that gave the clear priority would lose the error.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic [1:0] {
    RESP_DONE    = 2'd0,
    RESP_TIMEOUT = 2'd1,
    RESP_MABORT  = 2'd2,
    RESP_DONE_X  = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_st_e;

  localparam int unsigned WAM_OFFSET  = 15;
  localparam int unsigned SMI_EN_BIT  = 4;
  localparam int unsigned TABORT_BIT  = 11;
endpackage

// File: rtl/dmf_cmd_decode.sv
module dmf_cmd_decode #(
  parameter int unsigned HOST_AW  = 16,
  parameter int unsigned DMA_LO   = 'h00C0,
  parameter int unsigned DMA_HI   = 'h00DF,
  parameter int unsigned CLR_ADDR = 'h00DC
) (
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               busy,
  output logic               cmd_fire,
  output logic               host_retry
);
  localparam logic [HOST_AW-1:0] LO_A  = DMA_LO[HOST_AW-1:0];
  localparam logic [HOST_AW-1:0] HI_A  = DMA_HI[HOST_AW-1:0];
  localparam logic [HOST_AW-1:0] CLR_A = CLR_ADDR[HOST_AW-1:0];

  logic in_window;
  logic is_clear;

  always_comb begin
    in_window  = (host_addr >= LO_A) && (host_addr <= HI_A);
    is_clear   = host_req && host_we && (host_addr == CLR_A);
    host_retry = host_req && in_window && busy;
    cmd_fire   = is_clear && !busy;
  end
endmodule

// File: rtl/dmf_addr_gen.sv
module dmf_addr_gen
  import dmf_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DS_AW = 32,
  parameter int unsigned IW    = 2
) (
  input  logic [NCH*DS_AW-1:0] ch_base,
  input  logic [NCH-1:0]       pend,
  output logic [IW-1:0]        sel_idx,
  output logic [DS_AW-1:0]     sel_addr
);
  logic [DS_AW-1:0] wam_addr [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign wam_addr[g] = ch_base[g*DS_AW +: DS_AW]
                       + DS_AW'(g) + DS_AW'(WAM_OFFSET);
  end

  always_comb begin
    sel_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) sel_idx = IW'(i);
    end
    sel_addr = wam_addr[sel_idx];
  end
endmodule

// File: rtl/dmf_seq.sv
module dmf_seq
  import dmf_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_fire,
  input  logic [NCH-1:0] ch_valid,
  input  logic [IW-1:0]  sel_idx,
  input  logic           ds_ready,
  input  logic           ds_resp_valid,
  output logic [NCH-1:0] pend,
  output logic           busy,
  output logic           ds_valid,
  output logic           resp_take
);
  seq_st_e        state_q;
  logic [NCH-1:0] pend_q;
  logic [IW-1:0]  cur_q;
  logic [NCH-1:0] rest;

  always_comb begin
    rest      = pend_q & ~(NCH'(1) << cur_q);
    pend      = pend_q;
    busy      = (state_q != SEQ_IDLE);
    ds_valid  = (state_q == SEQ_ISSUE);
    resp_take = (state_q == SEQ_WAIT) && ds_resp_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (cmd_fire && (|ch_valid)) begin
            pend_q  <= ch_valid;
            state_q <= SEQ_ISSUE;
          end
        end
        SEQ_ISSUE: begin
          if (ds_ready) begin
            cur_q   <= sel_idx;
            state_q <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (ds_resp_valid) begin
            pend_q  <= rest;
            state_q <= (|rest) ? SEQ_ISSUE : SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  p_busy_from_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_fire));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |=> (ds_valid && (sel_idx == $past(sel_idx))));

  p_one_per_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_take |=> ($countones(pend) + 1 == $countones($past(pend))));
endmodule

// File: rtl/dmf_err.sv
module dmf_err
  import dmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resp_take,
  input  logic [1:0] resp_code,
  input  logic       smi_en,
  input  logic       sts_wr,
  input  logic       sts_clr,
  output logic       tabort,
  output logic       smi_pulse
);
  logic is_timeout;
  logic is_mabort;

  always_comb begin
    is_timeout = resp_take && (resp_e'(resp_code) == RESP_TIMEOUT);
    is_mabort  = resp_take && (resp_e'(resp_code) == RESP_MABORT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tabort    <= 1'b0;
      smi_pulse <= 1'b0;
    end else begin
      if (is_timeout)               tabort <= 1'b1;
      else if (sts_wr && sts_clr)   tabort <= 1'b0;
      smi_pulse <= is_mabort && smi_en;
    end
  end

  p_tabort_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tabort && !(sts_wr && sts_clr)) |=> tabort);

  p_smi_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |=> !smi_pulse);

  p_smi_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(smi_en));
endmodule

// File: rtl/dma_mask_fanout.sv
module dma_mask_fanout
  import dmf_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned HOST_AW  = 16,
  parameter int unsigned DS_AW    = 32,
  parameter int unsigned DS_DW    = 8,
  parameter int unsigned DMA_LO   = 'h00C0,
  parameter int unsigned DMA_HI   = 'h00DF,
  parameter int unsigned CLR_ADDR = 'h00DC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic [7:0]           host_wdata,
  output logic                 host_retry,
  input  logic [NCH-1:0]       ch_valid,
  input  logic [NCH*DS_AW-1:0] ch_base,
  output logic                 ds_valid,
  input  logic                 ds_ready,
  output logic [DS_AW-1:0]     ds_addr,
  output logic [DS_DW-1:0]     ds_data,
  input  logic                 ds_resp_valid,
  input  logic [1:0]           ds_resp,
  input  logic [7:0]           glbl_en,
  input  logic                 sts_wr,
  input  logic [15:0]          sts_wdata,
  output logic                 sts_tabort,
  output logic                 smi_pulse,
  output logic                 busy
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           cmd_fire;
  logic [NCH-1:0] pend;
  logic [IW-1:0]  sel_idx;
  logic           resp_take;
  logic           data_unused;

  assign data_unused = ^{host_wdata, sts_wdata, glbl_en};
  assign ds_data     = '0;

  dmf_cmd_decode #(
    .HOST_AW (HOST_AW),
    .DMA_LO  (DMA_LO),
    .DMA_HI  (DMA_HI),
    .CLR_ADDR(CLR_ADDR)
  ) i_decode (
    .host_req  (host_req),
    .host_we   (host_we),
    .host_addr (host_addr),
    .busy      (busy),
    .cmd_fire  (cmd_fire),
    .host_retry(host_retry)
  );

  dmf_addr_gen #(
    .NCH  (NCH),
    .DS_AW(DS_AW),
    .IW   (IW)
  ) i_addr (
    .ch_base (ch_base),
    .pend    (pend),
    .sel_idx (sel_idx),
    .sel_addr(ds_addr)
  );

  dmf_seq #(
    .NCH(NCH),
    .IW (IW)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_fire     (cmd_fire),
    .ch_valid     (ch_valid),
    .sel_idx      (sel_idx),
    .ds_ready     (ds_ready),
    .ds_resp_valid(ds_resp_valid),
    .pend         (pend),
    .busy         (busy),
    .ds_valid     (ds_valid),
    .resp_take    (resp_take)
  );

  dmf_err i_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .resp_take(resp_take),
    .resp_code(ds_resp),
    .smi_en   (glbl_en[SMI_EN_BIT]),
    .sts_wr   (sts_wr),
    .sts_clr  (sts_wdata[TABORT_BIT]),
    .tabort   (sts_tabort),
    .smi_pulse(smi_pulse)
  );

  p_retry_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_retry |-> busy);

  p_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> (ds_data == '0));
endmodule

// File: tb/test_dma_mask_fanout.sv
module test_dma_mask_fanout;
  localparam int unsigned NCH = 4;
  localparam int unsigned AW  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_req = 1'b0, host_we = 1'b0;
  logic [15:0]     host_addr = '0;
  logic [7:0]      host_wdata = '0;
  logic            host_retry;
  logic [NCH-1:0]  ch_valid = '0;
  logic [NCH*AW-1:0] ch_base;
  logic            ds_valid, ds_ready = 1'b0;
  logic [AW-1:0]   ds_addr;
  logic [7:0]      ds_data;
  logic            ds_resp_valid = 1'b0;
  logic [1:0]      ds_resp = '0;
  logic [7:0]      glbl_en = '0;
  logic            sts_wr = 1'b0;
  logic [15:0]     sts_wdata = '0;
  logic            sts_tabort, smi_pulse, busy;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] base_of(input int ch);
    return 32'h4000_0000 + 32'(ch) * 32'h0001_0000;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_base
    assign ch_base[g*AW +: AW] = base_of(g);
  end

  dma_mask_fanout i_dma_mask_fanout (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_retry(host_retry),
    .ch_valid(ch_valid), .ch_base(ch_base), .ds_valid(ds_valid),
    .ds_ready(ds_ready), .ds_addr(ds_addr), .ds_data(ds_data),
    .ds_resp_valid(ds_resp_valid), .ds_resp(ds_resp), .glbl_en(glbl_en),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_tabort(sts_tabort),
    .smi_pulse(smi_pulse), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_access(input logic [15:0] a, input logic we,
                             input logic [7:0] d, output logic retry_seen);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    #1 retry_seen = host_retry;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic serve(input int ch, input logic [1:0] r, input int stall,
                       input logic clr_too, output logic smi_s, output logic tab_s);
    logic [AW-1:0] exp_a;
    int waited;
    exp_a = base_of(ch) + 32'(ch) + 32'hF;
    waited = 0;
    while (!ds_valid && waited < 20) begin
      @(negedge clk); waited++;
    end
    chk(ds_valid, "R5 request present", 64'(ds_valid), 1);
    chk(ds_addr == exp_a, "R3 address", 64'(ds_addr), 64'(exp_a));
    chk(ds_data == 8'h00, "R4 data zero", 64'(ds_data), 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(ds_valid && ds_addr == exp_a, "R6 held under back-pressure", 64'(ds_addr), 64'(exp_a));
    end
    ds_ready = 1'b1;
    @(negedge clk);
    ds_ready = 1'b0;
    chk(!ds_valid && busy, "R5 waits for completion", 64'({busy, ds_valid}), 2);
    ds_resp_valid = 1'b1; ds_resp = r;
    if (clr_too) begin sts_wr = 1'b1; sts_wdata = 16'h0800; end
    @(negedge clk);
    ds_resp_valid = 1'b0; sts_wr = 1'b0; sts_wdata = '0;
    smi_s = smi_pulse; tab_s = sts_tabort;
  endtask

  task automatic sts_write(input logic [15:0] d);
    @(negedge clk);
    sts_wr = 1'b1; sts_wdata = d;
    @(negedge clk);
    sts_wr = 1'b0; sts_wdata = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !ds_valid && !smi_pulse && !sts_tabort && !host_retry,
        "R7 reset idle", 64'({busy, ds_valid, smi_pulse, sts_tabort, host_retry}), 0);
  endtask

  task automatic t_all_channels;
    logic rt, sm, tb;
    ch_valid = 4'b1111;
    host_access(16'h00DC, 1'b1, 8'hA5, rt);
    chk(!rt, "R8 no retry when idle", 64'(rt), 0);
    chk(busy, "R1 command with data A5 accepted, R7 busy", 64'(busy), 1);
    for (int c = 0; c < NCH; c++) begin
      serve(c, 2'd0, 0, 1'b0, sm, tb);
      if (c < NCH - 1) chk(busy, "R7 busy between writes", 64'(busy), 1);
    end
    chk(!busy && !ds_valid, "R7 busy falls after last", 64'(busy), 0);
  endtask

  task automatic t_sparse;
    logic rt, sm, tb;
    ch_valid = 4'b1010;
    host_access(16'h00DC, 1'b1, 8'h00, rt);
    chk(busy, "R1 command with data 00", 64'(busy), 1);
    serve(1, 2'd3, 0, 1'b0, sm, tb);
    serve(3, 2'd0, 3, 1'b0, sm, tb);
    chk(!busy, "R2 only two writes", 64'(busy), 0);
    repeat (2) @(negedge clk);
    chk(!ds_valid, "R2 no extra write", 64'(ds_valid), 0);
  endtask

  task automatic t_none_and_read;
    logic rt;
    ch_valid = 4'b0000;
    host_access(16'h00DC, 1'b1, 8'h11, rt);
    chk(!busy && !ds_valid, "R7 empty mask leaves busy low", 64'(busy), 0);
    ch_valid = 4'b1111;
    host_access(16'h00DC, 1'b0, 8'h00, rt);
    chk(!busy && !ds_valid, "R1 read starts nothing", 64'(busy), 0);
  endtask

  task automatic t_retry;
    logic rt, sm, tb;
    ch_valid = 4'b0100;
    host_access(16'h00DC, 1'b1, 8'h5A, rt);
    host_access(16'h00C0, 1'b0, 8'h00, rt);
    chk(rt, "R8 retry inside window", 64'(rt), 1);
    host_access(16'h0100, 1'b1, 8'h00, rt);
    chk(!rt, "R8 no retry outside window", 64'(rt), 0);
    host_access(16'h00DC, 1'b1, 8'hFF, rt);
    chk(rt, "R12 clear while busy retried", 64'(rt), 1);
    serve(2, 2'd0, 1, 1'b0, sm, tb);
    chk(!busy, "R12 sequence ends", 64'(busy), 0);
    repeat (3) @(negedge clk);
    chk(!busy && !ds_valid, "R12 no second sequence", 64'({busy, ds_valid}), 0);
    host_access(16'h00DF, 1'b0, 8'h00, rt);
    chk(!rt, "R8 no retry after sequence", 64'(rt), 0);
  endtask

  task automatic t_timeout;
    logic rt, sm, tb;
    ch_valid = 4'b0111;
    host_access(16'h00DC, 1'b1, 8'h00, rt);
    serve(0, 2'd0, 0, 1'b0, sm, tb);
    chk(!tb, "R9 no abort yet", 64'(tb), 0);
    serve(1, 2'd1, 0, 1'b0, sm, tb);
    chk(tb, "R9 timeout sets status", 64'(tb), 1);
    serve(2, 2'd0, 0, 1'b0, sm, tb);
    chk(tb, "R9 status sticky, sequence continued", 64'(tb), 1);
    chk(!busy, "R9 sequence completes", 64'(busy), 0);
    sts_write(16'h0001);
    chk(sts_tabort, "R10 other bits do not clear", 64'(sts_tabort), 1);
    sts_write(16'h0800);
    chk(!sts_tabort, "R10 write one clears", 64'(sts_tabort), 0);
  endtask

  task automatic t_set_wins;
    logic rt, sm, tb;
    ch_valid = 4'b0001;
    host_access(16'h00DC, 1'b1, 8'h00, rt);
    serve(0, 2'd1, 0, 1'b1, sm, tb);
    chk(tb, "R10 timeout beats simultaneous clear", 64'(tb), 1);
    sts_write(16'h0800);
  endtask

  task automatic t_smi;
    logic rt, sm, tb;
    glbl_en = 8'h10;
    ch_valid = 4'b0001;
    host_access(16'h00DC, 1'b1, 8'h00, rt);
    serve(0, 2'd2, 0, 1'b0, sm, tb);
    chk(sm, "R11 SMI on master abort when enabled", 64'(sm), 1);
    chk(!tb, "R11 abort leaves status clear", 64'(tb), 0);
    @(negedge clk);
    chk(!smi_pulse, "R11 SMI one cycle", 64'(smi_pulse), 0);
    glbl_en = 8'hEF;
    ch_valid = 4'b1000;
    host_access(16'h00DC, 1'b1, 8'h00, rt);
    serve(3, 2'd2, 0, 1'b0, sm, tb);
    chk(!sm, "R11 no SMI when bit 4 clear", 64'(sm), 0);
    glbl_en = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_channels();
    t_sparse();
    t_none_and_read();
    t_retry();
    t_timeout();
    t_set_wins();
    t_smi();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule